// File: doc/BRIEF.md
# Dual-Edge Interrupt Aggregator with Interleaved Readout

The block watches a bank of asynchronous input lines. For each line it keeps two pending flags, one for rising edges and one for falling edges. Each flag is gated by its own enable bit. Any visible pending flag pulls the active-low interrupt output low. This tells a host that something needs attention.

The host reaches the block through a byte-stream command port, which stands in for a slow serial bus. A frame-start strobe opens a frame, and the first byte received is the command. Command 0x01 loads both enable masks from eight argument bytes. Command 0x02 returns the pending flags one byte per request and clears each byte as it is delivered.

Masks and flags travel as interleaved rise/fall byte pairs, lowest line numbers first. A host that only cares about the low-numbered lines can therefore stop after the first pair. Bytes it never reads stay pending.

Top module: `edge_irq_hub`

## Requirements
- R1: After reset both masks are zero, no flag is pending, `irq_n_o` is 1, `tx_valid_o` is 0 and `tx_byte_o` is 0x00.
- R2: Command byte 0x01 takes eight following bytes in slot order k = 0..7. Even slot k holds rising-enable bits [8(k/2)+7 : 8(k/2)] and odd slot k holds the falling-enable bits of the same lines. Both masks change together on the clock edge that accepts the eighth byte. All-zero masks stop any flag from being raised.
- R3: A rising flag is raised only when its line's rising-enable bit is 1. A line with neither enable bit raises nothing.
- R4: A falling flag needs its falling-enable bit. With both bits set, a high-then-low pulse leaves both flags of that line pending.
- R5: Inputs cross two synchronizer flops. A line change applied before clock edge k becomes a pending flag at edge k+2.
- R6: `irq_n_o` is 0 exactly when some pending flag has its enable bit set.
- R7: After command 0x02, each one-cycle `tx_req_i` pulse returns the next slot on `tx_byte_o`, with `tx_valid_o` high for one cycle after the requesting edge. Slots use the same order as in R2. The byte returned is the pending flags ANDed with their enables.
- R8: Delivering a slot clears the flags of that byte only. Slots not yet delivered when the frame ends stay pending.
- R9: An edge that would raise a flag on the same edge that clears its byte leaves that flag pending. It is absent from the byte just returned.
- R10: Requests past the eighth slot return 0x00 with `tx_valid_o` high and clear nothing.
- R11: Any other command byte makes the block ignore all further bytes and requests until the next `frame_start_i`. `tx_valid_o` stays 0 and the masks do not change.
- R12: A `frame_start_i` during a mask load abandons it and leaves the masks as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lines_i | input | 32 | Asynchronous lines being watched |
| frame_start_i | input | 1 | One-cycle strobe that opens a command frame |
| rx_valid_i | input | 1 | Host-to-block byte present this cycle |
| rx_byte_i | input | 8 | Host-to-block byte |
| tx_req_i | input | 1 | One-cycle request for the next reply byte |
| tx_valid_o | output | 1 | Reply byte valid (one cycle per request) |
| tx_byte_o | output | 8 | Reply byte, 0x00 when not valid |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
A behavioural reference model runs alongside the design and is compared on every clock. Single lines are toggled with no enable, with rise only, with fall only and with both bits set. These cases separate a missing gate from a swapped rise/fall slot. A line in the top byte is read both by a two-byte short read and by a full read, which shows whether clears stay confined to delivered slots. An edge is placed on exactly the clearing cycle to separate set-wins from clear-wins. Unknown commands and aborted mask loads are followed by toggles on lines those masks would have enabled, so any leaked mask change shows up on the interrupt pin.

// File: rtl/eia_pkg.sv
package eia_pkg;
  typedef enum logic [1:0] {
    PS_CMD,
    PS_MASK,
    PS_READ,
    PS_DROP
  } port_st_e;

  localparam logic [7:0] OP_SET_MASK  = 8'h01;
  localparam logic [7:0] OP_READ_CLR  = 8'h02;
endpackage

// File: rtl/eia_edge_detect.sv
module eia_edge_detect #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  logic [N_LINES-1:0] meta_q;
  logic [N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= lines_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise_o = sync_q & ~prev_q;
    fall_o = ~sync_q & prev_q;
  end

  // R5: a detected rising edge means the line was high two edges earlier
  assert_sync_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & ~$past(lines_i, 2)) == '0));
  assert_sync_depth_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_o & $past(lines_i, 2)) == '0));
endmodule

// File: rtl/eia_pend_bank.sv
module eia_pend_bank #(
  parameter int N_LINES = 32,
  localparam int NBYTES = N_LINES / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] rise_edge_i,
  input  logic [N_LINES-1:0] fall_edge_i,
  input  logic [N_LINES-1:0] rise_en_i,
  input  logic [N_LINES-1:0] fall_en_i,
  input  logic [NBYTES-1:0]  rise_clr_i,
  input  logic [NBYTES-1:0]  fall_clr_i,
  output logic [N_LINES-1:0] rise_vis_o,
  output logic [N_LINES-1:0] fall_vis_o
);
  logic [N_LINES-1:0] rise_q, rise_n;
  logic [N_LINES-1:0] fall_q, fall_n;
  logic [N_LINES-1:0] rise_set, fall_set;
  logic [N_LINES-1:0] rise_wipe, fall_wipe;

  for (genvar j = 0; j < NBYTES; j++) begin : g_wipe
    assign rise_wipe[8*j +: 8] = {8{rise_clr_i[j]}};
    assign fall_wipe[8*j +: 8] = {8{fall_clr_i[j]}};
  end

  always_comb begin
    rise_set   = rise_edge_i & rise_en_i;
    fall_set   = fall_edge_i & fall_en_i;
    rise_n     = (rise_q & ~rise_wipe) | rise_set;
    fall_n     = (fall_q & ~fall_wipe) | fall_set;
    rise_vis_o = rise_q & rise_en_i;
    fall_vis_o = fall_q & fall_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_n;
      fall_q <= fall_n;
    end
  end

  // R3: a new rising flag needs its enable bit in the cycle it was raised
  assert_rise_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & ~$past(rise_q) & ~$past(rise_en_i)) == '0));
  // R4: same gate on the falling side
  assert_fall_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_q & ~$past(fall_q) & ~$past(fall_en_i)) == '0));
  // R8: a wiped byte holds no flag unless a new edge arrived with the wipe
  assert_wipe_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & $past(rise_wipe & ~rise_set)) == '0 &&
     (fall_q & $past(fall_wipe & ~fall_set)) == '0));
  // R9: a set on the clearing edge is never lost
  assert_set_beats_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rise_q & $past(rise_set)) == '0 && (~fall_q & $past(fall_set)) == '0));
endmodule

// File: rtl/eia_cmd_port.sv
module eia_cmd_port
  import eia_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int NBYTES = N_LINES / 8,
  localparam int NSLOTS = 2 * NBYTES,
  localparam int IDXW   = $clog2(NSLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               tx_req_i,
  input  logic [N_LINES-1:0] rise_vis_i,
  input  logic [N_LINES-1:0] fall_vis_i,
  output logic [N_LINES-1:0] rise_en_o,
  output logic [N_LINES-1:0] fall_en_o,
  output logic [NBYTES-1:0]  rise_clr_o,
  output logic [NBYTES-1:0]  fall_clr_o,
  output logic               tx_valid_o,
  output logic [7:0]         tx_byte_o
);
  port_st_e              st_q, st_n;
  logic [IDXW-1:0]       idx_q, idx_n;
  logic [8*NSLOTS-1:0]   shadow_q, shadow_n;
  logic [N_LINES-1:0]    rise_en_q, fall_en_q;
  logic [N_LINES-1:0]    new_rise, new_fall;
  logic [8*NSLOTS-1:0]   vis_slots;
  logic [NSLOTS-1:0]     slot_clr;
  logic [7:0]            sel_byte;
  logic                  commit;
  logic                  txv_q, txv_n;
  logic [7:0]            txb_q, txb_n;

  // interleave: even slot = rising byte, odd slot = falling byte of same lines
  for (genvar j = 0; j < NBYTES; j++) begin : g_slot
    assign vis_slots[16*j +: 8]     = rise_vis_i[8*j +: 8];
    assign vis_slots[16*j + 8 +: 8] = fall_vis_i[8*j +: 8];
    assign new_rise[8*j +: 8]       = shadow_n[16*j +: 8];
    assign new_fall[8*j +: 8]       = shadow_n[16*j + 8 +: 8];
    assign rise_clr_o[j]            = slot_clr[2*j];
    assign fall_clr_o[j]            = slot_clr[2*j + 1];
  end

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < NSLOTS; k++) begin
      if (idx_q == IDXW'(k)) sel_byte = vis_slots[8*k +: 8];
    end
  end

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    shadow_n = shadow_q;
    commit   = 1'b0;
    txv_n    = 1'b0;
    txb_n    = '0;
    slot_clr = '0;
    if (frame_start_i) begin
      st_n  = PS_CMD;
      idx_n = '0;
    end else begin
      unique case (st_q)
        PS_CMD: begin
          if (rx_valid_i) begin
            idx_n = '0;
            if (rx_byte_i == OP_SET_MASK)      st_n = PS_MASK;
            else if (rx_byte_i == OP_READ_CLR) st_n = PS_READ;
            else                               st_n = PS_DROP;
          end
        end
        PS_MASK: begin
          if (rx_valid_i) begin
            for (int k = 0; k < NSLOTS; k++) begin
              if (idx_q == IDXW'(k)) shadow_n[8*k +: 8] = rx_byte_i;
            end
            if (idx_q == IDXW'(NSLOTS - 1)) begin
              commit = 1'b1;
              st_n   = PS_DROP;
            end else begin
              idx_n = idx_q + IDXW'(1);
            end
          end
        end
        PS_READ: begin
          if (tx_req_i) begin
            txv_n = 1'b1;
            txb_n = sel_byte;
            for (int k = 0; k < NSLOTS; k++) begin
              if (idx_q == IDXW'(k)) slot_clr[k] = 1'b1;
            end
            if (idx_q != IDXW'(NSLOTS)) idx_n = idx_q + IDXW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_CMD;
      idx_q     <= '0;
      shadow_q  <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      txv_q     <= 1'b0;
      txb_q     <= '0;
    end else begin
      st_q     <= st_n;
      idx_q    <= idx_n;
      shadow_q <= shadow_n;
      txv_q    <= txv_n;
      txb_q    <= txb_n;
      if (commit) begin
        rise_en_q <= new_rise;
        fall_en_q <= new_fall;
      end
    end
  end

  assign rise_en_o  = rise_en_q;
  assign fall_en_o  = fall_en_q;
  assign tx_valid_o = txv_q;
  assign tx_byte_o  = txb_q;

  // R10: slot counter saturates one past the last slot
  assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDXW'(NSLOTS));
  // R12: masks move only on the edge that accepts the final argument byte
  assert_mask_atomic_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> ($stable(rise_en_q) && $stable(fall_en_q)));
  // R11: a reply byte only follows a request made in the read state
  assert_reply_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> ($past(tx_req_i) && $past(st_q == PS_READ)));
endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub #(
  parameter int N_LINES = 32,
  localparam int NBYTES = N_LINES / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               frame_start_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               tx_req_i,
  output logic               tx_valid_o,
  output logic [7:0]         tx_byte_o,
  output logic               irq_n_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] rise_edge, fall_edge;
  logic [N_LINES-1:0] rise_en, fall_en;
  logic [N_LINES-1:0] rise_vis, fall_vis;
  logic [NBYTES-1:0]  rise_clr, fall_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eia_edge_detect #(.N_LINES(N_LINES)) i_detect (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lines_i (lines_i),
    .rise_o  (rise_edge),
    .fall_o  (fall_edge)
  );

  eia_pend_bank #(.N_LINES(N_LINES)) i_bank (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rise_edge_i (rise_edge),
    .fall_edge_i (fall_edge),
    .rise_en_i   (rise_en),
    .fall_en_i   (fall_en),
    .rise_clr_i  (rise_clr),
    .fall_clr_i  (fall_clr),
    .rise_vis_o  (rise_vis),
    .fall_vis_o  (fall_vis)
  );

  eia_cmd_port #(.N_LINES(N_LINES)) i_port (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .frame_start_i (frame_start_i),
    .rx_valid_i    (rx_valid_i),
    .rx_byte_i     (rx_byte_i),
    .tx_req_i      (tx_req_i),
    .rise_vis_i    (rise_vis),
    .fall_vis_i    (fall_vis),
    .rise_en_o     (rise_en),
    .fall_en_o     (fall_en),
    .rise_clr_o    (rise_clr),
    .fall_clr_o    (fall_clr),
    .tx_valid_o    (tx_valid_o),
    .tx_byte_o     (tx_byte_o)
  );

  assign irq_n_o = ~(|rise_vis | |fall_vis);

  // R6: with both masks zero the interrupt line cannot be active
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise_en == '0 && fall_en == '0) |-> irq_n_o);
  // R1: reply byte is zero whenever it is not valid
  assert_idle_reply_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tx_valid_o |-> (tx_byte_o == 8'h00));
endmodule

// File: tb/test_edge_irq_hub.sv
module test_edge_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lines;
  logic        frame_start, rx_valid, tx_req;
  logic [7:0]  rx_byte;
  logic        tx_valid_o, irq_n_o;
  logic [7:0]  tx_byte_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  edge_irq_hub i_edge_irq_hub (
    .clk           (clk),
    .rst_n         (rst_n),
    .lines_i       (lines),
    .frame_start_i (frame_start),
    .rx_valid_i    (rx_valid),
    .rx_byte_i     (rx_byte),
    .tx_req_i      (tx_req),
    .tx_valid_o    (tx_valid_o),
    .tx_byte_o     (tx_byte_o),
    .irq_n_o       (irq_n_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_re, m_fe, m_rp, m_fp;
  logic [31:0] hist[$];
  logic [7:0]  m_sh [8];
  int          m_st, m_idx, m_rel;
  logic        e_irq_n, e_txv;
  logic [7:0]  e_txb;
  logic [31:0] rs, fs, rc, fc, nr, nf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_re = 0; m_fe = 0; m_rp = 0; m_fp = 0;
      hist = '{32'h0, 32'h0, 32'h0, 32'h0};
      m_st = 0; m_idx = 0; m_rel = 0;
      for (int k = 0; k < 8; k++) m_sh[k] = 8'h00;
      e_irq_n = 1'b1; e_txv = 1'b0; e_txb = 8'h00;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      hist.push_front(lines);
      void'(hist.pop_back());
      rs = hist[2] & ~hist[3] & m_re;
      fs = ~hist[2] & hist[3] & m_fe;
      rc = 0; fc = 0;
      e_txv = 1'b0; e_txb = 8'h00;
      if (frame_start) begin
        m_st = 0; m_idx = 0;
      end else if (m_st == 0) begin
        if (rx_valid) begin
          m_idx = 0;
          m_st = (rx_byte == 8'h01) ? 1 : (rx_byte == 8'h02) ? 2 : 3;
        end
      end else if (m_st == 1) begin
        if (rx_valid) begin
          m_sh[m_idx] = rx_byte;
          if (m_idx == 7) begin
            for (int j = 0; j < 4; j++) begin
              nr[8*j +: 8] = m_sh[2*j];
              nf[8*j +: 8] = m_sh[2*j+1];
            end
            m_st = 3;
          end else m_idx++;
        end
      end else if (m_st == 2) begin
        if (tx_req) begin
          e_txv = 1'b1;
          if (m_idx < 8) begin
            if (m_idx % 2 == 0) begin
              e_txb = 8'((m_rp & m_re) >> (8*(m_idx/2)));
              rc = 32'hFF << (8*(m_idx/2));
            end else begin
              e_txb = 8'((m_fp & m_fe) >> (8*(m_idx/2)));
              fc = 32'hFF << (8*(m_idx/2));
            end
            m_idx++;
          end
        end
      end
      m_rp = (m_rp & ~rc) | rs;
      m_fp = (m_fp & ~fc) | fs;
      if (m_st == 3 && m_idx == 7 && !frame_start && rx_valid) begin
        m_re = nr; m_fe = nf; m_idx = 8;
      end
      e_irq_n = ((m_rp & m_re) | (m_fp & m_fe)) == 0;
    end
  end

  // continuous per-clock comparison
  always @(negedge clk) begin
    check("R6 irq_n vs model", {31'b0, irq_n_o}, {31'b0, e_irq_n});
    check("R7 tx_valid vs model", {31'b0, tx_valid_o}, {31'b0, e_txv});
    check("R7 tx_byte vs model", {24'b0, tx_byte_o}, {24'b0, e_txb});
  end

  // ---------------- host tasks (entered at a negedge) ----------------
  task automatic frame();
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask
  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
  endtask
  task automatic req(output logic [7:0] got);
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0; got = tx_byte_o;
  endtask
  task automatic load_masks(input logic [31:0] r, input logic [31:0] f);
    frame(); send(8'h01);
    for (int j = 0; j < 4; j++) begin
      send(r[8*j +: 8]); send(f[8*j +: 8]);
    end
    frame();
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] got;

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lines = '0; frame_start = 0; rx_valid = 0; rx_byte = 0; tx_req = 0;
    idle(3); rst_n = 1'b1; idle(4);
    check("R1 irq_n after reset", {31'b0, irq_n_o}, 32'd1);
    check("R1 tx_valid after reset", {31'b0, tx_valid_o}, 32'd0);

    // zero masks: toggles raise nothing
    lines[5] = 1'b1; idle(5);
    check("R2 zero masks keep irq high", {31'b0, irq_n_o}, 32'd1);
    lines[5] = 1'b0; idle(4);

    // rise: lines 0 and 2; fall: lines 2 and 31
    load_masks(32'h0000_0005, 32'h8000_0004);
    idle(2);

    // R5: latency through synchronizer
    lines[0] = 1'b1;
    idle(1); check("R5 edge+0 no flag", {31'b0, irq_n_o}, 32'd1);
    idle(1); check("R5 edge+1 no flag", {31'b0, irq_n_o}, 32'd1);
    idle(1); check("R5 flag at edge+2", {31'b0, irq_n_o}, 32'd0);

    // R3: unenabled line
    lines[1] = 1'b1; idle(4); lines[1] = 1'b0; idle(4);
    // R4: both edges on line 2, falling on line 31
    lines[2] = 1'b1; idle(4); lines[2] = 1'b0; idle(4);
    lines[31] = 1'b1; idle(4); lines[31] = 1'b0; idle(4);

    // short read of first pair
    frame(); send(8'h02);
    req(got); check("R7 slot0 rise byte0 (R3 line1 absent)", {24'b0, got}, 32'h05);
    req(got); check("R4 slot1 fall byte0", {24'b0, got}, 32'h04);
    frame(); idle(2);
    check("R8 unread slot7 keeps irq low", {31'b0, irq_n_o}, 32'd0);

    // full read
    frame(); send(8'h02);
    for (int k = 0; k < 8; k++) begin
      req(got);
      check("R8 full read slot", {24'b0, got}, (k == 7) ? 32'h80 : 32'h00);
    end
    req(got); check("R10 ninth slot zero", {24'b0, got}, 32'h00);
    check("R10 ninth slot valid", {31'b0, tx_valid_o}, 32'd1);
    frame(); idle(1);
    check("R8 all read irq high", {31'b0, irq_n_o}, 32'd1);

    // R9: edge lands on the clearing edge
    lines[0] = 1'b0; idle(4);
    frame(); send(8'h02);
    lines[0] = 1'b1; idle(2);
    req(got);
    check("R9 byte excludes same-edge flag", {24'b0, got}, 32'h00);
    check("R9 flag stays pending", {31'b0, irq_n_o}, 32'd0);
    frame(); send(8'h02);
    req(got); check("R9 flag read later", {24'b0, got}, 32'h01);
    frame(); idle(1);
    check("R9 cleared afterwards", {31'b0, irq_n_o}, 32'd1);

    // R11: unknown command swallows a mask load and requests
    frame(); send(8'h33); send(8'h01);
    for (int k = 0; k < 8; k++) send(8'hFF);
    req(got); check("R11 no reply after bad command", {31'b0, tx_valid_o}, 32'd0);
    frame();
    lines[3] = 1'b1; idle(4); lines[3] = 1'b0; idle(4);
    check("R11 masks unchanged", {31'b0, irq_n_o}, 32'd1);

    // R12: aborted mask load
    frame(); send(8'h01); send(8'hFF); send(8'hFF); send(8'hFF); frame();
    lines[3] = 1'b1; idle(4); lines[3] = 1'b0; idle(4);
    check("R12 aborted load ignored", {31'b0, irq_n_o}, 32'd1);

    // R2: slot order, line 8 through slot 2
    load_masks(32'h0000_0100, 32'h0);
    lines[8] = 1'b1; idle(4);
    check("R2 slot2 enables line8", {31'b0, irq_n_o}, 32'd0);
    frame(); send(8'h02);
    req(got); check("R2 slot0 empty", {24'b0, got}, 32'h00);
    req(got); check("R2 slot1 empty", {24'b0, got}, 32'h00);
    req(got); check("R7 slot2 rise byte1", {24'b0, got}, 32'h01);
    frame();
    load_masks(32'h0, 32'h0);
    lines[8] = 1'b0; idle(4); lines[8] = 1'b1; idle(4);
    check("R2 zero masks disable", {31'b0, irq_n_o}, 32'd1);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule